// File: doc/BRIEF.md
# Exponent-Clamped Floating-Point Reciprocal

This block takes a 32-bit operand in the IEEE-754 binary32 layout and returns an approximate reciprocal in the same layout, as a fixed-function perspective-divide stage would. The lowest bit of the operand is cleared before anything else looks at it. The fraction of the reciprocal comes from a pipelined restoring divider that truncates toward zero.

The block then limits the result's exponent to a symmetric window of plus or minus `EXP_LIMIT`, which is 64 by default. The limit acts on the exponent field only. The divider's fraction bits pass through untouched, so a result that falls outside the window is not saturated. Instead it wraps into the binade at the edge of the window. Zero, denormal, infinite and NaN operands each produce a fixed result.

The unit is fully pipelined and accepts one operand in every cycle. Its latency is `ceil(FRAC_BITS / BITS_PER_STAGE) + 2` cycles, which is 8 with the default parameters.

Top module: `recip_expclamp`

## Requirements
- R1: Bit 0 of `in_op` is treated as 0. Two operands that differ only in bit 0 give identical results. An operand with exponent field 0xFF whose only set fraction bit is bit 0 is handled as an infinity.
- R2: For every operand that is not a NaN, result bit 31 equals operand bit 31.
- R3: For a normal operand with biased exponent E, the unbiased result exponent before clamping is 127−E when the masked fraction is zero, and 126−E otherwise. When the masked fraction is zero, the result fraction is zero.
- R4: For a normal operand with nonzero masked fraction f, the result fraction field (bits 22:0) is the low 23 bits of floor(2^47 / (2^23 + f)). The top `FRAC_BITS` of those bits are correct and the rest are zero, so the result never exceeds the exact reciprocal and is short of it by less than 2^(23−FRAC_BITS) fraction units.
- R5: If the unbiased result exponent exceeds +EXP_LIMIT, the exponent field becomes 127+EXP_LIMIT (191 by default) and the fraction field is the unchanged R4/R3 value.
- R6: If the unbiased result exponent is below −EXP_LIMIT, the exponent field becomes 127−EXP_LIMIT (63 by default) and the fraction field is unchanged. Exponents exactly at ±EXP_LIMIT are kept as they are.
- R7: A zero or denormal operand (exponent field 0) gives {sign, 127+EXP_LIMIT, fraction 0}.
- R8: An infinite operand (exponent field 0xFF, masked fraction 0) gives {sign, 127−EXP_LIMIT, fraction 0}.
- R9: A NaN operand (exponent field 0xFF, masked fraction nonzero) gives 0x7FC00000 regardless of its sign.
- R10: `out_valid` rises exactly LATENCY cycles after the edge that accepts `in_valid`, where LATENCY = ceil(FRAC_BITS/BITS_PER_STAGE)+2 (8 by default). One operand may be accepted per cycle, results keep input order, and every operand yields exactly one result.
- R11: While `rst_n` is low, `out_valid` is 0. Operands accepted before a reset never produce a result after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset that empties the pipeline |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Operand in binary32 layout |
| out_valid | output | 1 | Result strobe, LATENCY cycles after `in_valid` |
| out_res | output | 32 | Clamped reciprocal in binary32 layout |

## Verification
The exponent clamp and the fraction pass-through act on the same result in the same cycle. The bench provokes this with operands far beyond either end of the window that carry non-trivial fractions, such as 1.5×2^100 and 1.25×2^−100. It judges each such result bit-exactly: the exponent field must sit at the edge of the window while the fraction still matches the truncated reciprocal. The bench also streams back-to-back operands while the clamp, the special-class paths and a reset are exercised, so a stage that mixes up neighbouring operands shows up as a mismatch or a latency error.

// File: rtl/recip_pkg.sv
package recip_pkg;

   localparam int F32_W     = 32;
   localparam int F32_MANT  = 23;
   localparam int F32_EXPW  = 8;
   localparam int F32_BIAS  = 127;
   localparam int DIV_W     = F32_MANT + 1;
   localparam logic [F32_W-1:0] CANON_QNAN = 32'h7FC0_0000;

   // operand class after the low-bit mask
   typedef enum logic [1:0] {
      CLS_NORM = 2'd0,
      CLS_ZERO = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } op_class_e;

   // sideband carried alongside the divider
   typedef struct packed {
      logic              sign;
      op_class_e         cls;
      logic              unit;   // masked fraction is zero
      logic signed [9:0] rexp;   // unclamped unbiased result exponent
   } recip_side_t;

endpackage

// File: rtl/recip_unpack.sv
module recip_unpack
   import recip_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [F32_W-1:0]     in_op,
   output logic                 v_out,
   output recip_side_t          side_out,
   output logic [DIV_W-1:0]     div_out,
   output logic [DIV_W-1:0]     rem_out
);

   logic [F32_W-1:0]     op_m;
   logic [F32_EXPW-1:0]  bexp;
   logic [F32_MANT-1:0]  frac;
   logic signed [9:0]    bexp_s;
   recip_side_t          side_d;
   logic [DIV_W-1:0]     div_d;

   // R1: low operand bit is cleared before any decoding
   assign op_m   = in_op & ~32'h0000_0001;
   assign bexp   = op_m[30:23];
   assign frac   = op_m[22:0];
   assign bexp_s = $signed({2'b00, bexp});
   assign div_d  = {1'b1, frac};

   always_comb begin
      side_d.sign = op_m[31];
      side_d.unit = (frac == '0);
      side_d.rexp = side_d.unit ? (10'sd127 - bexp_s) : (10'sd126 - bexp_s);
      if (bexp == '0)
         side_d.cls = CLS_ZERO;
      else if (bexp == '1)
         side_d.cls = (frac == '0) ? CLS_INF : CLS_NAN;
      else
         side_d.cls = CLS_NORM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out    <= 1'b0;
         side_out <= '0;
         div_out  <= '0;
         rem_out  <= '0;
      end else begin
         v_out    <= in_valid;
         side_out <= side_d;
         div_out  <= div_d;
         // leading quotient bit is always 1: seed with 2^24 - divisor
         rem_out  <= ~div_d + 1'b1;
      end
   end

endmodule

// File: rtl/recip_div_stage.sv
module recip_div_stage
   import recip_pkg::*;
#(
   parameter int QW    = 23,
   parameter int NBITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_in,
   input  recip_side_t          side_in,
   input  logic [DIV_W-1:0]     div_in,
   input  logic [DIV_W-1:0]     rem_in,
   input  logic [QW-1:0]        q_in,
   output logic                 v_out,
   output recip_side_t          side_out,
   output logic [DIV_W-1:0]     div_out,
   output logic [DIV_W-1:0]     rem_out,
   output logic [QW-1:0]        q_out
);

   logic [DIV_W-1:0] rem_d;
   logic [QW-1:0]    q_d;

   // NBITS restoring steps, one quotient bit each
   always_comb begin
      logic [DIV_W:0] trial;
      rem_d = rem_in;
      q_d   = q_in;
      for (int i = 0; i < NBITS; i++) begin
         trial = {rem_d, 1'b0};
         if (trial >= {1'b0, div_in}) begin
            trial = trial - {1'b0, div_in};
            q_d   = {q_d[QW-2:0], 1'b1};
         end else begin
            q_d   = {q_d[QW-2:0], 1'b0};
         end
         rem_d = trial[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out    <= 1'b0;
         side_out <= '0;
         div_out  <= '0;
         rem_out  <= '0;
         q_out    <= '0;
      end else begin
         v_out    <= v_in;
         side_out <= side_in;
         div_out  <= div_in;
         rem_out  <= rem_d;
         q_out    <= q_d;
      end
   end

endmodule

// File: rtl/recip_pack.sv
module recip_pack
   import recip_pkg::*;
#(
   parameter int FRAC_BITS = 23,
   parameter int EXP_LIMIT = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_in,
   input  recip_side_t          side_in,
   input  logic [FRAC_BITS-1:0] q_in,
   output logic                 out_valid,
   output logic [F32_W-1:0]     out_res
);

   localparam int SHIFT = F32_MANT - FRAC_BITS;
   localparam logic signed [9:0] LIM_S = 10'(EXP_LIMIT);
   localparam logic [F32_EXPW-1:0] EXP_HI = 8'(F32_BIAS + EXP_LIMIT);
   localparam logic [F32_EXPW-1:0] EXP_LO = 8'(F32_BIAS - EXP_LIMIT);

   logic signed [9:0]    rexp_c;
   logic [F32_MANT-1:0]  mant;
   logic [F32_W-1:0]     res_d;

   always_comb begin
      // R5/R6: exponent-only clamp
      if (side_in.rexp > LIM_S)
         rexp_c = LIM_S;
      else if (side_in.rexp < -LIM_S)
         rexp_c = -LIM_S;
      else
         rexp_c = side_in.rexp;

      mant = side_in.unit ? '0 : (F32_MANT'(q_in) << SHIFT);

      unique case (side_in.cls)
         CLS_NAN:  res_d = CANON_QNAN;                              // R9
         CLS_ZERO: res_d = {side_in.sign, EXP_HI, {F32_MANT{1'b0}}}; // R7
         CLS_INF:  res_d = {side_in.sign, EXP_LO, {F32_MANT{1'b0}}}; // R8
         default:  res_d = {side_in.sign, 8'(rexp_c + 10'sd127), mant};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
      end else begin
         out_valid <= v_in;
         out_res   <= res_d;
      end
   end

endmodule

// File: rtl/recip_expclamp.sv
module recip_expclamp
   import recip_pkg::*;
#(
   parameter int FRAC_BITS      = 23,
   parameter int BITS_PER_STAGE = 4,
   parameter int EXP_LIMIT      = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_op,
   output logic        out_valid,
   output logic [31:0] out_res
);

   localparam int NSTG    = (FRAC_BITS + BITS_PER_STAGE - 1) / BITS_PER_STAGE;
   localparam int LATENCY = NSTG + 2;

   if (FRAC_BITS < 16 || FRAC_BITS > F32_MANT) begin : g_bad_frac
      $error("FRAC_BITS must lie in 16..23");
   end
   if (BITS_PER_STAGE < 1 || BITS_PER_STAGE > FRAC_BITS) begin : g_bad_bps
      $error("BITS_PER_STAGE must lie in 1..FRAC_BITS");
   end
   if (EXP_LIMIT < 1 || EXP_LIMIT > 126) begin : g_bad_lim
      $error("EXP_LIMIT must lie in 1..126");
   end

   logic                 v_c    [0:NSTG];
   recip_side_t          side_c [0:NSTG];
   logic [DIV_W-1:0]     div_c  [0:NSTG];
   logic [DIV_W-1:0]     rem_c  [0:NSTG];
   logic [FRAC_BITS-1:0] q_c    [0:NSTG];

   assign q_c[0] = '0;

   recip_unpack i_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_op    (in_op),
      .v_out    (v_c[0]),
      .side_out (side_c[0]),
      .div_out  (div_c[0]),
      .rem_out  (rem_c[0])
   );

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      localparam int NB = ((s + 1) * BITS_PER_STAGE <= FRAC_BITS) ?
                          BITS_PER_STAGE : (FRAC_BITS - s * BITS_PER_STAGE);
      recip_div_stage #(
         .QW    (FRAC_BITS),
         .NBITS (NB)
      ) i_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .v_in     (v_c[s]),
         .side_in  (side_c[s]),
         .div_in   (div_c[s]),
         .rem_in   (rem_c[s]),
         .q_in     (q_c[s]),
         .v_out    (v_c[s+1]),
         .side_out (side_c[s+1]),
         .div_out  (div_c[s+1]),
         .rem_out  (rem_c[s+1]),
         .q_out    (q_c[s+1])
      );
   end

   recip_pack #(
      .FRAC_BITS (FRAC_BITS),
      .EXP_LIMIT (EXP_LIMIT)
   ) i_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .v_in      (v_c[NSTG]),
      .side_in   (side_c[NSTG]),
      .q_in      (q_c[NSTG]),
      .out_valid (out_valid),
      .out_res   (out_res)
   );

endmodule

// File: rtl/recip_expclamp_chk.sv
module recip_expclamp_chk #(
   parameter int LATENCY   = 8,
   parameter int EXP_LIMIT = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_op,
   input logic        out_valid,
   input logic [31:0] out_res
);

   logic [LATENCY-1:0] vsh;
   logic [31:0]        opsh [LATENCY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsh <= '0;
         for (int i = 0; i < LATENCY; i++) opsh[i] <= '0;
      end else begin
         vsh     <= {vsh[LATENCY-2:0], in_valid};
         opsh[0] <= in_op;
         for (int i = 1; i < LATENCY; i++) opsh[i] <= opsh[i-1];
      end
   end

   logic        d_sign, d_nan, d_inf, d_zero, d_low_nan;
   logic [7:0]  d_exp;
   logic [21:0] d_frac_hi;

   assign d_sign    = opsh[LATENCY-1][31];
   assign d_exp     = opsh[LATENCY-1][30:23];
   assign d_frac_hi = opsh[LATENCY-1][22:1];
   assign d_nan     = (d_exp == 8'hFF) && (d_frac_hi != '0);
   assign d_inf     = (d_exp == 8'hFF) && (d_frac_hi == '0);
   assign d_zero    = (d_exp == 8'h00);
   assign d_low_nan = d_inf && opsh[LATENCY-1][0];

   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vsh[LATENCY-1]);

   a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !d_nan) |-> (out_res[31] == d_sign));

   a_r9_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_nan) |-> (out_res == 32'h7FC0_0000));

   a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_zero) |-> (out_res[30:0] == {8'(127 + EXP_LIMIT), 23'd0}));

   a_r8_inf: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_inf) |-> (out_res[30:0] == {8'(127 - EXP_LIMIT), 23'd0}));

   a_r1_low_bit_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && d_low_nan) |-> (out_res != 32'h7FC0_0000));

   // R5 and R6: exponent field stays inside the window
   a_r5_exp_window: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !d_nan) |->
      ((out_res[30:23] <= 8'(127 + EXP_LIMIT)) && (out_res[30:23] >= 8'(127 - EXP_LIMIT))));

endmodule

bind recip_expclamp recip_expclamp_chk #(
   .LATENCY   (LATENCY),
   .EXP_LIMIT (EXP_LIMIT)
) i_recip_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .out_valid (out_valid),
   .out_res   (out_res)
);

// File: tb/test_recip_expclamp.sv
`timescale 1ns/1ps
module test_recip_expclamp;

   localparam int FB  = 23;
   localparam int BPS = 4;
   localparam int LIM = 64;
   localparam int LAT = (FB + BPS - 1) / BPS + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_op = '0;
   logic        out_valid;
   logic [31:0] out_res;

   always #2.5 clk = ~clk;

   recip_expclamp #(
      .FRAC_BITS      (FB),
      .BITS_PER_STAGE (BPS),
      .EXP_LIMIT      (LIM)
   ) i_recip_expclamp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_op     (in_op),
      .out_valid (out_valid),
      .out_res   (out_res)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [31:0] q_exp [$];
   string       q_tag [$];
   int          q_cyc [$];
   int tests = 0;
   int fails = 0;

   function automatic logic [31:0] model(input logic [31:0] op);
      logic [31:0] o;
      logic [7:0]  e;
      logic [22:0] f;
      logic [63:0] q;
      int          re;
      o = op & 32'hFFFF_FFFE;
      e = o[30:23];
      f = o[22:0];
      if (e == 8'hFF) return (f != 0) ? 32'h7FC0_0000 : {o[31], 8'(127 - LIM), 23'd0};
      if (e == 8'h00) return {o[31], 8'(127 + LIM), 23'd0};
      if (f == 0) begin
         q  = '0;
         re = 127 - int'(e);
      end else begin
         q  = (64'd1 << 47) / {40'd0, 1'b1, f};
         re = 126 - int'(e);
      end
      if (re > LIM)  re = LIM;
      if (re < -LIM) re = -LIM;
      return {o[31], 8'(re + 127), q[22:0]};
   endfunction

   task automatic drive(input logic [31:0] op, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      q_exp.push_back(model(op));
      q_tag.push_back(tag);
      q_cyc.push_back(cyc);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_op    = '0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_exp.size() == 0) begin
            tests++; fails++;
            $display("FAIL R10 unexpected result actual %h expected none", out_res);
         end else begin
            logic [31:0] ex;
            string       tg;
            int          c0, d;
            ex = q_exp.pop_front();
            tg = q_tag.pop_front();
            c0 = q_cyc.pop_front();
            tests++;
            if (ex == 32'h7FC0_0000 || out_res == 32'h7FC0_0000) begin
               if (out_res != ex) begin
                  fails++;
                  $display("FAIL %s actual %h expected %h", tg, out_res, ex);
               end
            end else begin
               d = int'(ex[22:0]) - int'(out_res[22:0]);
               if (out_res[31:23] != ex[31:23] || d < 0 || d >= (1 << (23 - FB))) begin
                  fails++;
                  $display("FAIL %s actual %h expected %h", tg, out_res, ex);
               end
            end
            tests++;
            if (cyc - c0 != LAT) begin
               fails++;
               $display("FAIL R10 latency actual %0d expected %0d", cyc - c0, LAT);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R10 watchdog expired actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      tests++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R11 reset out_valid actual %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      idle(2);

      // R3: exact powers of two
      drive(32'h3F80_0000, "R3");
      drive(32'h4000_0000, "R3");
      drive(32'h3E80_0000, "R3");
      // R4: truncated fractions
      drive(32'h4040_0000, "R4");
      drive(32'h3FC0_0000, "R4");
      drive(32'h40E0_0000, "R4");
      drive(32'h3FFF_FFFE, "R4");
      // R2: negative operands
      drive(32'hC0A0_0000, "R2");
      drive(32'hBF80_0000, "R2");
      // R1: low bit ignored, low-bit-only NaN treated as infinity
      drive(32'h3FC0_0001, "R1");
      drive(32'h4040_0001, "R1");
      drive(32'h7F80_0001, "R1");
      drive(32'hFF80_0001, "R1");
      idle(3);
      // R5: upper clamp with wrap, and boundary
      drive(32'h1FC0_0000, "R5");   // 1.5*2^-64 -> exp 63+? : 126-63 = 63 in range
      drive(32'h0DA0_0000, "R5");   // 1.25*2^-100 wraps to top binade
      drive(32'h1F80_0000, "R5");   // 2^-64 -> exactly +64
      drive(32'h1F00_0000, "R5");   // 2^-65 -> +65 clamps
      drive(32'h1F40_0000, "R5");   // 1.5*2^-65 -> +64 kept
      // R6: lower clamp with wrap, and boundary
      drive(32'h71C0_0000, "R6");   // 1.5*2^100
      drive(32'h5F80_0000, "R6");   // 2^64 -> exactly -64
      drive(32'h5FC0_0000, "R6");   // 1.5*2^64 -> -65 clamps
      drive(32'h6000_0000, "R6");   // 2^65 -> -65 clamps
      drive(32'hF1C0_0000, "R6");
      // R7: zero and denormal
      drive(32'h0000_0000, "R7");
      drive(32'h8000_0000, "R7");
      drive(32'h0000_0010, "R7");
      drive(32'h807F_FFFF, "R7");
      // R8: infinities
      drive(32'h7F80_0000, "R8");
      drive(32'hFF80_0000, "R8");
      // R9: NaNs
      drive(32'h7FC0_0000, "R9");
      drive(32'hFFFF_FFFF, "R9");
      drive(32'h7F80_0002, "R9");
      idle(2);

      // R4 and R10: back-to-back random normals with occasional gaps
      for (int i = 0; i < 300; i++) begin
         logic [31:0] r;
         logic [7:0]  e;
         r = $urandom;
         e = 8'(1 + ($urandom % 254));
         drive({r[31], e, r[22:0]}, "R4");
         if (i % 37 == 36) idle(3);
      end
      idle(LAT + 4);

      // R11: reset drops operands in flight
      drive(32'h4040_0000, "R11");
      drive(32'h4080_0000, "R11");
      drive(32'h40A0_0000, "R11");
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      q_exp.delete();
      q_tag.delete();
      q_cyc.delete();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < LAT + 2; i++) begin
         @(negedge clk);
         tests++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 stale result actual %b expected 0", out_valid);
         end
      end

      // pipeline usable after reset
      drive(32'h4000_0000, "R11");
      idle(LAT + 4);

      tests++;
      if (q_exp.size() != 0) begin
         fails++;
         $display("FAIL R10 missing results actual %0d expected 0", q_exp.size());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule